// File: doc/BRIEF.md
# Hardwired Accumulator Instruction Sequencer

This block is the control unit and register set of a very small single-accumulator processor. A hardwired decoder steps it through register-transfer groups, one group per clock. A 2-bit cycle code names the current phase: fetch, indirect, execute or interrupt. A step counter inside the phase selects which transfer group is active, and it returns to its first step whenever a phase finishes. The block holds a memory address register, a memory buffer register, a program counter, an instruction register and one working accumulator.

The block drives a synchronous single-port memory and runs three real instructions: add-to-accumulator, increment-and-skip-if-zero, and branch-and-save-address. It resolves one level of indirect addressing in hardware. When an interrupt is taken, it saves the program counter to a fixed location and jumps to a fixed service address.

An instruction word is 16 bits. Bit 15 is the indirect flag, bits 14:12 are the opcode and bits 11:0 are the address. The memory registers its read data: the address and read strobe presented in one clock produce valid `mem_rdata` in the next clock. A write happens at the clock edge that ends the step in which `mem_wr` is high.

Top module: `acc_seq_ctrl`

## Requirements
- R1: The cycle code reads 00 in fetch, 01 in indirect, 10 in execute and 11 in interrupt. Fetch is followed by indirect when bit 15 of the fetched word is 1, and by execute otherwise. Indirect is always followed by execute. Execute is followed by interrupt or by fetch. Interrupt is always followed by fetch.
- R2: Fetch lasts 3 clocks. It reads memory at the program counter, loads the word into the instruction register and leaves the program counter one higher.
- R3: ADD (opcode 001 in bits 14:12) lasts 3 execute clocks and adds the memory word at the address in bits 11:0 to the accumulator.
- R4: Indirect lasts 3 clocks. It replaces the instruction's address field with bits 11:0 of the memory word at that address, so execute then works on the resolved address.
- R5: ISZ (opcode 010) lasts 4 execute clocks. It writes the memory word plus one back to the same location. When that result is zero, it increments the program counter once more, which skips the next instruction.
- R6: BSA (opcode 011) lasts 3 execute clocks. It writes the address of the following instruction into location X and leaves the program counter at X+1.
- R7: The interrupt request is examined only at the end of execute. The interrupt phase lasts 3 clocks, writes the program counter to address 0x000, sets the program counter to 0x001 and then returns to fetch.
- R8: Any other opcode (000 or 100 to 111) completes in 1 execute clock. It leaves the accumulator and memory unchanged and returns to fetch.
- R9: An interrupt-enable bit is set by reset and cleared on entry to the interrupt phase. While it is clear, the request input has no effect.
- R10: Reset puts the program counter at 0x010, the accumulator at 0 and the cycle code at fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Registered read data from memory |
| mem_addr | output | 12 | Memory address (the value the address register holds or is loading) |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| cyc_code | output | 2 | Current instruction cycle code |
| acc_out | output | 16 | Accumulator contents |
| pc_out | output | 12 | Program counter contents |

## Verification
Every result has a fixed clock count after reset release, found by adding phase lengths: 3 for fetch, 3 for indirect, 3 for ADD, 4 for ISZ, 3 for BSA, 1 for an unknown opcode and 3 for interrupt. The bench releases reset on a falling edge and advances an exact number of rising edges per phase. It samples on the next falling edge, so each check lands on the first clock in which the new cycle code, program counter, accumulator or memory word should appear. The interrupt test keeps the request high through fetch to show that it waits for the end of execute. It then checks that a second execute with the request still high goes back to fetch.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
   localparam int OP_W = 3;

   typedef enum logic [1:0] {
      CY_FETCH = 2'b00,
      CY_INDIR = 2'b01,
      CY_EXEC  = 2'b10,
      CY_INTR  = 2'b11
   } cyc_e;

   localparam logic [OP_W-1:0] OPC_ADD = 3'b001;
   localparam logic [OP_W-1:0] OPC_ISZ = 3'b010;
   localparam logic [OP_W-1:0] OPC_BSA = 3'b011;

   typedef enum logic [1:0] {MA_HOLD, MA_PC, MA_IRA, MA_SAVE} mar_sel_e;
   typedef enum logic [1:0] {MB_HOLD, MB_MEM, MB_PC, MB_INC} mbr_sel_e;

   typedef struct packed {
      mar_sel_e mar_sel;
      mbr_sel_e mbr_sel;
      logic     pc_inc;
      logic     pc_isz;
      logic     pc_ld_ira;
      logic     pc_ld_vec;
      logic     ir_ld;
      logic     ir_ad_ld;
      logic     acc_add;
      logic     rd;
      logic     wr;
      logic     done;
   } ctl_t;
endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
   import acc_seq_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  cyc_e              cyc,
   input  logic [STEP_W-1:0] step,
   input  logic [OP_W-1:0]   opc,
   output ctl_t              ctl
);
   always_comb begin
      ctl = '0;
      unique case (cyc)
         CY_FETCH: begin
            case (int'(step))
               0: begin ctl.mar_sel = MA_PC; ctl.rd = 1'b1; end
               1: begin ctl.mbr_sel = MB_MEM; ctl.pc_inc = 1'b1; end
               2: begin ctl.ir_ld = 1'b1; ctl.done = 1'b1; end
               default: ctl.done = 1'b1;
            endcase
         end
         CY_INDIR: begin
            case (int'(step))
               0: begin ctl.mar_sel = MA_IRA; ctl.rd = 1'b1; end
               1: ctl.mbr_sel = MB_MEM;
               2: begin ctl.ir_ad_ld = 1'b1; ctl.done = 1'b1; end
               default: ctl.done = 1'b1;
            endcase
         end
         CY_EXEC: begin
            if (opc == OPC_ADD || opc == OPC_ISZ) begin
               case (int'(step))
                  0: begin ctl.mar_sel = MA_IRA; ctl.rd = 1'b1; end
                  1: ctl.mbr_sel = MB_MEM;
                  2: begin
                     if (opc == OPC_ADD) begin
                        ctl.acc_add = 1'b1;
                        ctl.done    = 1'b1;
                     end else begin
                        ctl.mbr_sel = MB_INC;
                     end
                  end
                  3: begin ctl.wr = 1'b1; ctl.pc_isz = 1'b1; ctl.done = 1'b1; end
                  default: ctl.done = 1'b1;
               endcase
            end else if (opc == OPC_BSA) begin
               case (int'(step))
                  0: begin ctl.mar_sel = MA_IRA; ctl.mbr_sel = MB_PC; end
                  1: begin ctl.pc_ld_ira = 1'b1; ctl.wr = 1'b1; end
                  2: begin ctl.pc_inc = 1'b1; ctl.done = 1'b1; end
                  default: ctl.done = 1'b1;
               endcase
            end else begin
               ctl.done = 1'b1;
            end
         end
         CY_INTR: begin
            case (int'(step))
               0: ctl.mbr_sel = MB_PC;
               1: begin ctl.mar_sel = MA_SAVE; ctl.pc_ld_vec = 1'b1; end
               2: begin ctl.wr = 1'b1; ctl.done = 1'b1; end
               default: ctl.done = 1'b1;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/acc_seq_seqr.sv
module acc_seq_seqr
   import acc_seq_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              go_ind,
   input  logic              take_irq,
   output cyc_e              cyc,
   output logic [STEP_W-1:0] step
);
   cyc_e cyc_nx;

   always_comb begin
      unique case (cyc)
         CY_FETCH: cyc_nx = go_ind ? CY_INDIR : CY_EXEC;
         CY_INDIR: cyc_nx = CY_EXEC;
         CY_EXEC:  cyc_nx = take_irq ? CY_INTR : CY_FETCH;
         CY_INTR:  cyc_nx = CY_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc  <= CY_FETCH;
         step <= '0;
      end else if (done) begin
         cyc  <= cyc_nx;
         step <= '0;
      end else begin
         step <= step + STEP_W'(1);
      end
   end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int                   DATA_W    = 16,
   parameter int                   ADDR_W    = 12,
   parameter int                   STEP_W    = 3,
   parameter logic [ADDR_W-1:0]    RST_PC    = 'h010,
   parameter logic [ADDR_W-1:0]    SAVE_ADDR = 'h000,
   parameter logic [ADDR_W-1:0]    VEC_ADDR  = 'h001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [1:0]        cyc_code,
   output logic [DATA_W-1:0] acc_out,
   output logic [ADDR_W-1:0] pc_out
);
   localparam int IND_BIT = DATA_W - 1;
   localparam int OPC_LSB = ADDR_W;

   if (DATA_W != ADDR_W + OP_W + 1) begin : g_bad_width
      $error("acc_seq_ctrl: DATA_W must equal ADDR_W + opcode width + 1");
   end
   if (STEP_W < 2) begin : g_bad_step
      $error("acc_seq_ctrl: STEP_W must cover at least four steps");
   end

   logic [ADDR_W-1:0] mar_q, mar_nx, pc_q;
   logic [DATA_W-1:0] mbr_q, ir_q, acc_q;
   logic              ien_q;
   cyc_e              cyc;
   logic [STEP_W-1:0] step;
   ctl_t              ctl;
   logic              take_irq;

   assign take_irq = irq & ien_q;

   acc_seq_seqr #(.STEP_W(STEP_W)) u_seqr (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (ctl.done),
      .go_ind   (mbr_q[IND_BIT]),
      .take_irq (take_irq),
      .cyc      (cyc),
      .step     (step)
   );

   acc_seq_decode #(.STEP_W(STEP_W)) u_dec (
      .cyc  (cyc),
      .step (step),
      .opc  (ir_q[OPC_LSB +: OP_W]),
      .ctl  (ctl)
   );

   always_comb begin
      unique case (ctl.mar_sel)
         MA_PC:   mar_nx = pc_q;
         MA_IRA:  mar_nx = ir_q[ADDR_W-1:0];
         MA_SAVE: mar_nx = SAVE_ADDR;
         default: mar_nx = mar_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mar_q <= '0;
         mbr_q <= '0;
         ir_q  <= '0;
         acc_q <= '0;
         pc_q  <= RST_PC;
         ien_q <= 1'b1;
      end else begin
         mar_q <= mar_nx;
         unique case (ctl.mbr_sel)
            MB_MEM:  mbr_q <= mem_rdata;
            MB_PC:   mbr_q <= {{(DATA_W-ADDR_W){1'b0}}, pc_q};
            MB_INC:  mbr_q <= mbr_q + DATA_W'(1);
            default: mbr_q <= mbr_q;
         endcase
         if (ctl.ir_ld)
            ir_q <= mbr_q;
         else if (ctl.ir_ad_ld)
            ir_q <= {ir_q[DATA_W-1:ADDR_W], mbr_q[ADDR_W-1:0]};
         if (ctl.acc_add)
            acc_q <= acc_q + mbr_q;
         if (ctl.pc_ld_vec)
            pc_q <= VEC_ADDR;
         else if (ctl.pc_ld_ira)
            pc_q <= ir_q[ADDR_W-1:0];
         else if (ctl.pc_inc || (ctl.pc_isz && mbr_q == '0))
            pc_q <= pc_q + ADDR_W'(1);
         if (ctl.done && cyc == CY_EXEC && take_irq)
            ien_q <= 1'b0;
      end
   end

   assign mem_addr  = mar_nx;
   assign mem_wdata = mbr_q;
   assign mem_rd    = ctl.rd;
   assign mem_wr    = ctl.wr;
   assign cyc_code  = cyc;
   assign acc_out   = acc_q;
   assign pc_out    = pc_q;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk #(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] SAVE_ADDR = 'h000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cyc_code,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] pc_out
);
   // R1
   fetch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_code == 2'b00 |=> cyc_code != 2'b11);
   // R1
   indir_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_code == 2'b01 |=> (cyc_code == 2'b01 || cyc_code == 2'b10));
   // R7
   intr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_code == 2'b11 |=> (cyc_code == 2'b11 || cyc_code == 2'b00));
   // R2
   fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_code == 2'b00 && mem_rd) |-> mem_addr == pc_out);
   // R7
   save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_code == 2'b11 && mem_wr) |-> mem_addr == SAVE_ADDR);
   // R5
   no_rd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
endmodule

bind acc_seq_ctrl acc_seq_chk #(.ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cyc_code (cyc_code),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .pc_out   (pc_out)
);

// File: tb/sim_acc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_acc_seq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [15:0] mem_rdata;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic        mem_rd, mem_wr;
   logic [1:0]  cyc_code;
   logic [15:0] acc_out;
   logic [11:0] pc_out;

   logic [15:0] mem [0:4095];
   int vectors = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   acc_seq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .cyc_code(cyc_code), .acc_out(acc_out), .pc_out(pc_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic restart();
      rst_n = 1'b0;
      irq   = 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go();
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      restart();
      chk("R10 cycle code in reset", 32'(cyc_code), 32'h0);
      chk("R10 pc in reset", 32'(pc_out), 32'h010);
      chk("R10 acc in reset", 32'(acc_out), 32'h0);
   endtask

   task automatic t_add();
      restart();
      mem[12'h010] = 16'h1100; mem[12'h100] = 16'd5;
      mem[12'h011] = 16'h1101; mem[12'h101] = 16'd7;
      go();
      run(3);
      chk("R1 fetch to execute", 32'(cyc_code), 32'h2);
      chk("R2 pc after fetch", 32'(pc_out), 32'h011);
      run(3);
      chk("R3 acc after first add", 32'(acc_out), 32'd5);
      chk("R1 execute back to fetch", 32'(cyc_code), 32'h0);
      run(6);
      chk("R3 acc after second add", 32'(acc_out), 32'd12);
      chk("R2 pc after two instructions", 32'(pc_out), 32'h012);
   endtask

   task automatic t_indirect();
      restart();
      mem[12'h010] = 16'h9200; mem[12'h200] = 16'hA300; mem[12'h300] = 16'd9;
      go();
      run(3);
      chk("R1 fetch to indirect", 32'(cyc_code), 32'h1);
      run(3);
      chk("R4 indirect to execute", 32'(cyc_code), 32'h2);
      chk("R4 acc unchanged during indirect", 32'(acc_out), 32'h0);
      run(3);
      chk("R4 acc via resolved address", 32'(acc_out), 32'd9);
      chk("R4 pc after indirect add", 32'(pc_out), 32'h011);
   endtask

   task automatic t_isz();
      restart();
      mem[12'h010] = 16'h2400; mem[12'h400] = 16'hFFFF;
      go();
      run(6);
      chk("R5 still executing at 6 clocks", 32'(cyc_code), 32'h2);
      run(1);
      chk("R5 written value wraps to zero", 32'(mem[12'h400]), 32'h0);
      chk("R5 skip taken on zero", 32'(pc_out), 32'h012);
      restart();
      mem[12'h010] = 16'h2400; mem[12'h400] = 16'd5;
      go();
      run(7);
      chk("R5 written value incremented", 32'(mem[12'h400]), 32'd6);
      chk("R5 no skip on nonzero", 32'(pc_out), 32'h011);
   endtask

   task automatic t_bsa();
      restart();
      mem[12'h010] = 16'h3500;
      go();
      run(6);
      chk("R6 return address stored at X", 32'(mem[12'h500]), 32'h011);
      chk("R6 pc at X+1", 32'(pc_out), 32'h501);
      chk("R6 back to fetch", 32'(cyc_code), 32'h0);
   endtask

   task automatic t_unknown();
      restart();
      mem[12'h010] = 16'h1100; mem[12'h100] = 16'd5;
      mem[12'h011] = 16'h7100;
      go();
      run(9);
      chk("R8 unknown opcode in execute", 32'(cyc_code), 32'h2);
      run(1);
      chk("R8 one clock then fetch", 32'(cyc_code), 32'h0);
      chk("R8 acc unchanged", 32'(acc_out), 32'd5);
      chk("R8 memory unchanged", 32'(mem[12'h100]), 32'd5);
      chk("R8 pc advanced", 32'(pc_out), 32'h012);
   endtask

   task automatic t_interrupt();
      restart();
      mem[12'h010] = 16'h1100; mem[12'h100] = 16'd3;
      mem[12'h001] = 16'h0000;
      go();
      irq = 1'b1;
      run(3);
      chk("R7 request ignored until execute ends", 32'(cyc_code), 32'h2);
      run(3);
      chk("R7 enter interrupt after execute", 32'(cyc_code), 32'h3);
      chk("R7 instruction completed first", 32'(acc_out), 32'd3);
      run(3);
      chk("R7 back to fetch", 32'(cyc_code), 32'h0);
      chk("R7 pc at service address", 32'(pc_out), 32'h001);
      chk("R7 pc saved at 0x000", 32'(mem[12'h000]), 32'h011);
      run(4);
      chk("R9 request ignored once enable cleared", 32'(cyc_code), 32'h0);
      chk("R9 pc continues in routine", 32'(pc_out), 32'h002);
      irq = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_add();
      t_indirect();
      t_isz();
      t_bsa();
      t_unknown();
      t_interrupt();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule